// File: doc/BRIEF.md
# Byte-Stream Instruction Fetch Unit

This block feeds a byte-coded instruction stream to an execution engine without the engine spending any ALU cycles on address increments or operand assembly. It owns a byte-granular fetch pointer and reads whole words from a word-addressed memory port ahead of demand. It holds the fetched bytes in a short shift queue. The head of the queue is offered two ways: as a single byte, and as a 16-bit pair made of the two oldest bytes. Each view is given in a zero-extended and a sign-extended 32-bit form.

The consumer pulses `rd_byte` or `rd_half` in the cycle it takes a value. The queue then drops one or two bytes, and word reads resume as soon as a full word fits. A branch is taken by pulsing `pc_load` with a new byte address. This empties the queue, discards any word already in flight, and restarts fetching at that address. When the address is not word-aligned, the leading bytes of the first word are skipped.

Top module: `bytefetch_unit`

## Requirements
- R1: After reset both valid flags are low, and `mem_req` is high with `mem_addr` equal to the reset byte address shifted right by two.
- R2: The byte view carries the oldest queued byte in bits 7:0. `mbr1_zext` has zeros above it, and `mbr1_sext` has bit 7 copied into bits 31:8.
- R3: The pair view is big-endian: the oldest byte is in bits 15:8 and the next one in bits 7:0. `mbr2_zext` is zero above bit 15, and `mbr2_sext` has bit 15 copied into bits 31:16.
- R4: A `rd_byte` pulse with at least one byte queued removes exactly one byte, so the next byte of the stream becomes the head.
- R5: A `rd_half` pulse with at least two bytes queued removes exactly two bytes. When both strobes are high in the same cycle, the two-byte read takes effect.
- R6: A word read is requested only when the queue has room for a whole word (free slots at least 4) and no earlier read is still waiting for its data. At most one read is outstanding at any time.
- R7: `mem_addr` is the fetch byte pointer divided by 4. Within a returned word, the byte at the lowest address sits in bits 7:0, so the stream order is bits 7:0, 15:8, 23:16, 31:24.
- R8: A `pc_load` pulse empties the queue by the next cycle. The stream then restarts at `pc_value`. Read strobes in that same cycle are ignored.
- R9: Data for a read issued before a `pc_load` (in flight, or granted in the same cycle) is discarded and never enters the queue.
- R10: After a load to an address with byte offset k inside its word, the first 4-k bytes taken from that word are the ones at offsets k..3.
- R11: A read strobe issued with too few bytes queued for it leaves the queue unchanged.
- R12: `mbr1_valid` is high exactly when at least one byte is queued, and `mbr2_valid` exactly when at least two are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_load | input | 1 | Redirect the stream to `pc_value` |
| pc_value | input | ADDR_W | New byte address |
| rd_byte | input | 1 | Consume one byte |
| rd_half | input | 1 | Consume two bytes |
| mbr1_valid | output | 1 | At least one byte queued |
| mbr1_zext | output | 32 | Head byte, zero-extended |
| mbr1_sext | output | 32 | Head byte, sign-extended |
| mbr2_valid | output | 1 | At least two bytes queued |
| mbr2_zext | output | 32 | Head pair, zero-extended |
| mbr2_sext | output | 32 | Head pair, sign-extended |
| mem_req | output | 1 | Word read request |
| mem_addr | output | ADDR_W-2 | Word address of the request |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |

## Verification
The bench builds the block with its default parameters: a 6-byte queue, 4-byte words and 32-bit addresses. It pairs the block with a memory model that answers three cycles after each grant and whose grants can be switched off. With a 6-byte queue a second word is held back until two bytes are taken, so the room rule for requests can be seen at the ports. The three-cycle latency keeps a read in flight across back-to-back redirects, which exercises the discard path. Switching grants off after an unaligned load leaves exactly one byte queued, so the alignment skip and the ignored two-byte read can both be observed.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   parameter int BFU_OUT_W = 32;
   typedef logic [7:0] bfu_byte_t;
endpackage

// File: rtl/bfu_extend.sv
module bfu_extend
   import bfu_pkg::*;
#(
   parameter int IN_W = 8
) (
   input  logic [IN_W-1:0]      val,
   output logic [BFU_OUT_W-1:0] zext,
   output logic [BFU_OUT_W-1:0] sext
);
   generate
      if (IN_W < BFU_OUT_W) begin : g_pad
         assign zext = {{(BFU_OUT_W-IN_W){1'b0}}, val};
         assign sext = {{(BFU_OUT_W-IN_W){val[IN_W-1]}}, val};
      end else begin : g_pass
         assign zext = val[BFU_OUT_W-1:0];
         assign sext = val[BFU_OUT_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/bfu_byte_queue.sv
module bfu_byte_queue
   import bfu_pkg::*;
#(
   parameter int QDEPTH     = 6,
   parameter int WORD_BYTES = 4,
   localparam int WORD_W    = 8 * WORD_BYTES,
   localparam int OFS_W     = $clog2(WORD_BYTES),
   localparam int CNT_W     = $clog2(QDEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [1:0]        pop_n,
   input  logic              push_en,
   input  logic [WORD_W-1:0] push_word,
   input  logic [OFS_W-1:0]  push_skip,
   output bfu_byte_t         head0,
   output bfu_byte_t         head1,
   output logic [CNT_W-1:0]  count
);
   bfu_byte_t        slot_q [QDEPTH];
   bfu_byte_t        slot_d [QDEPTH];
   logic [CNT_W-1:0] count_q, count_d;

   always_comb begin
      int keep;
      int push_cnt;
      keep     = int'(count_q) - int'(pop_n);
      push_cnt = push_en ? (WORD_BYTES - int'(push_skip)) : 0;
      for (int i = 0; i < QDEPTH; i++) begin
         if (i < keep) begin
            slot_d[i] = slot_q[i + int'(pop_n)];
         end else if ((i - keep) < push_cnt) begin
            slot_d[i] = push_word[8*(int'(push_skip) + i - keep) +: 8];
         end else begin
            slot_d[i] = slot_q[i];
         end
      end
      count_d = CNT_W'(keep + push_cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         for (int i = 0; i < QDEPTH; i++) slot_q[i] <= '0;
      end else if (flush) begin
         count_q <= '0;
      end else begin
         count_q <= count_d;
         for (int i = 0; i < QDEPTH; i++) slot_q[i] <= slot_d[i];
      end
   end

   assign head0 = slot_q[0];
   assign head1 = slot_q[1];
   assign count = count_q;
endmodule

// File: rtl/bfu_fetch_ctrl.sv
module bfu_fetch_ctrl #(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int QDEPTH     = 6,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   localparam int WORD_W    = 8 * WORD_BYTES,
   localparam int OFS_W     = $clog2(WORD_BYTES),
   localparam int WADDR_W   = ADDR_W - OFS_W,
   localparam int CNT_W     = $clog2(QDEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pc_load,
   input  logic [ADDR_W-1:0]  pc_value,
   input  logic [CNT_W-1:0]   q_count,
   output logic               mem_req,
   output logic [WADDR_W-1:0] mem_addr,
   input  logic               mem_gnt,
   input  logic               mem_rvalid,
   input  logic [WORD_W-1:0]  mem_rdata,
   output logic               push_en,
   output logic [WORD_W-1:0]  push_word,
   output logic [OFS_W-1:0]   push_skip
);
   logic [WADDR_W-1:0] wptr_q;
   logic [OFS_W-1:0]   skip_q;
   logic               outst_q;
   logic               drop_q;
   logic               grant;

   assign mem_req   = !outst_q && (int'(q_count) <= (QDEPTH - WORD_BYTES));
   assign mem_addr  = wptr_q;
   assign grant     = mem_req && mem_gnt;
   assign push_en   = mem_rvalid && outst_q && !drop_q && !pc_load;
   assign push_word = mem_rdata;
   assign push_skip = skip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= RESET_PC[ADDR_W-1:OFS_W];
         skip_q  <= RESET_PC[OFS_W-1:0];
         outst_q <= 1'b0;
         drop_q  <= 1'b0;
      end else begin
         if (pc_load) begin
            wptr_q <= pc_value[ADDR_W-1:OFS_W];
            skip_q <= pc_value[OFS_W-1:0];
         end else begin
            if (grant)   wptr_q <= wptr_q + WADDR_W'(1);
            if (push_en) skip_q <= '0;
         end

         if (grant)           outst_q <= 1'b1;
         else if (mem_rvalid) outst_q <= 1'b0;

         if (pc_load)         drop_q <= grant || (outst_q && !mem_rvalid);
         else if (mem_rvalid) drop_q <= 1'b0;
      end
   end
endmodule

// File: rtl/bytefetch_unit.sv
module bytefetch_unit
   import bfu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int QDEPTH     = 6,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   localparam int WORD_W    = 8 * WORD_BYTES,
   localparam int OFS_W     = $clog2(WORD_BYTES),
   localparam int WADDR_W   = ADDR_W - OFS_W,
   localparam int CNT_W     = $clog2(QDEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pc_load,
   input  logic [ADDR_W-1:0]  pc_value,
   input  logic               rd_byte,
   input  logic               rd_half,
   output logic               mbr1_valid,
   output logic [31:0]        mbr1_zext,
   output logic [31:0]        mbr1_sext,
   output logic               mbr2_valid,
   output logic [31:0]        mbr2_zext,
   output logic [31:0]        mbr2_sext,
   output logic               mem_req,
   output logic [WADDR_W-1:0] mem_addr,
   input  logic               mem_gnt,
   input  logic               mem_rvalid,
   input  logic [WORD_W-1:0]  mem_rdata
);
   generate
      if (QDEPTH < WORD_BYTES || QDEPTH < 2) begin : g_bad_depth
         $error("queue depth must hold one word and at least two bytes");
      end
      if (WORD_BYTES < 2 || (1 << OFS_W) != WORD_BYTES) begin : g_bad_word
         $error("word size must be a power of two of at least two bytes");
      end
      if (BFU_OUT_W != 32) begin : g_bad_out
         $error("output views are 32 bits wide");
      end
   endgenerate

   logic [CNT_W-1:0]  q_count;
   logic [1:0]        pop_n;
   logic              push_en;
   logic [WORD_W-1:0] push_word;
   logic [OFS_W-1:0]  push_skip;
   bfu_byte_t         head0, head1;

   // the pair read wins; a load cancels both strobes
   always_comb begin
      pop_n = 2'd0;
      if (!pc_load) begin
         if (rd_half && q_count >= CNT_W'(2))      pop_n = 2'd2;
         else if (rd_byte && q_count >= CNT_W'(1)) pop_n = 2'd1;
      end
   end

   bfu_fetch_ctrl #(
      .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .QDEPTH(QDEPTH), .RESET_PC(RESET_PC)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_value(pc_value),
      .q_count(q_count), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .push_en(push_en), .push_word(push_word), .push_skip(push_skip)
   );

   bfu_byte_queue #(
      .QDEPTH(QDEPTH), .WORD_BYTES(WORD_BYTES)
   ) u_queue (
      .clk(clk), .rst_n(rst_n), .flush(pc_load), .pop_n(pop_n),
      .push_en(push_en), .push_word(push_word), .push_skip(push_skip),
      .head0(head0), .head1(head1), .count(q_count)
   );

   assign mbr1_valid = q_count >= CNT_W'(1);
   assign mbr2_valid = q_count >= CNT_W'(2);

   bfu_extend #(.IN_W(8)) u_ext1 (
      .val(head0), .zext(mbr1_zext), .sext(mbr1_sext)
   );

   bfu_extend #(.IN_W(16)) u_ext2 (
      .val({head0, head1}), .zext(mbr2_zext), .sext(mbr2_sext)
   );
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
   parameter int QDEPTH     = 6,
   parameter int WORD_BYTES = 4,
   parameter int CNT_W      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pc_load,
   input logic             rd_byte,
   input logic             rd_half,
   input logic             mbr1_valid,
   input logic             mbr2_valid,
   input logic             mem_req,
   input logic             mem_gnt,
   input logic             mem_rvalid,
   input logic [CNT_W-1:0] q_count
);
   // R12
   pair_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mbr2_valid |-> mbr1_valid);

   // R6
   single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> !mem_req);

   // R6
   word_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (int'(q_count) + WORD_BYTES <= QDEPTH));

   // R8
   load_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !mbr1_valid);

   // R4
   byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_byte && !rd_half && mbr1_valid && !pc_load && !mem_rvalid)
      |=> (q_count == CNT_W'($past(q_count) - CNT_W'(1))));

   // R5
   pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_half && mbr2_valid && !pc_load && !mem_rvalid)
      |=> (q_count == CNT_W'($past(q_count) - CNT_W'(2))));

   // R11
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mbr1_valid && !mem_rvalid) |=> !mbr1_valid);
endmodule

bind bytefetch_unit bfu_checker #(
   .QDEPTH(QDEPTH), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)
) u_bfu_chk (
   .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .rd_byte(rd_byte),
   .rd_half(rd_half), .mbr1_valid(mbr1_valid), .mbr2_valid(mbr2_valid),
   .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
   .q_count(q_count)
);

// File: tb/test_bytefetch_unit.sv
`timescale 1ns/1ps
module test_bytefetch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pc_load = 1'b0;
   logic [31:0] pc_value = '0;
   logic        rd_byte = 1'b0;
   logic        rd_half = 1'b0;
   logic        mbr1_valid, mbr2_valid;
   logic [31:0] mbr1_zext, mbr1_sext, mbr2_zext, mbr2_sext;
   logic        mem_req;
   logic [29:0] mem_addr;
   logic        mem_gnt;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        gnt_en = 1'b0;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int lat = 3;
   bit done = 0;
   logic [29:0] pend_a[$];
   int          pend_t[$];
   logic [7:0]  sb_q[$];

   always #4 clk = ~clk;

   assign mem_gnt = mem_req & gnt_en;

   bytefetch_unit i_bytefetch_unit (
      .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_value(pc_value),
      .rd_byte(rd_byte), .rd_half(rd_half),
      .mbr1_valid(mbr1_valid), .mbr1_zext(mbr1_zext), .mbr1_sext(mbr1_sext),
      .mbr2_valid(mbr2_valid), .mbr2_zext(mbr2_zext), .mbr2_sext(mbr2_sext),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] mem_byte(input logic [31:0] a);
      return 8'(a * 37 + 11);
   endfunction

   function automatic logic [31:0] mem_word(input logic [29:0] wa);
      logic [31:0] w;
      for (int b = 0; b < 4; b++) w[8*b +: 8] = mem_byte({wa, 2'b00} + 32'(b));
      return w;
   endfunction

   // memory model: grants seen after inputs settle, data after lat cycles
   initial begin
      forever begin
         @(negedge clk);
         #1;
         cyc++;
         mem_rvalid = 1'b0;
         if (pend_a.size() > 0 && pend_t[0] <= cyc) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem_word(pend_a.pop_front());
            void'(pend_t.pop_front());
         end
         if (mem_req && gnt_en) begin
            pend_a.push_back(mem_addr);
            pend_t.push_back(cyc + lat);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: redirect and load the scoreboard with the expected stream
   task automatic redirect(input logic [31:0] addr);
      @(negedge clk);
      pc_load  = 1'b1;
      pc_value = addr;
      sb_q.delete();
      for (int k = 0; k < 64; k++) sb_q.push_back(mem_byte(addr + 32'(k)));
      @(negedge clk);
      pc_load = 1'b0;
      chk("R8 empty after load", {31'd0, mbr1_valid}, 32'd0);
   endtask

   task automatic wait_flag(input bit pair);
      int n = 0;
      while (!(pair ? mbr2_valid : mbr1_valid) && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   // monitor side: pop expected bytes and compare with the head views
   task automatic read1(input string tag);
      logic [7:0] e;
      wait_flag(1'b0);
      e = sb_q.pop_front();
      chk({tag, " R2 zext"}, mbr1_zext, {24'd0, e});
      chk({tag, " R2 sext"}, mbr1_sext, {{24{e[7]}}, e});
      rd_byte = 1'b1;
      @(negedge clk);
      rd_byte = 1'b0;
   endtask

   task automatic read2(input string tag, input bit both);
      logic [7:0] e0, e1;
      wait_flag(1'b1);
      e0 = sb_q.pop_front();
      e1 = sb_q.pop_front();
      chk({tag, " R3 zext"}, mbr2_zext, {16'd0, e0, e1});
      chk({tag, " R3 sext"}, mbr2_sext, {{16{e0[7]}}, e0, e1});
      rd_half = 1'b1;
      rd_byte = both;
      @(negedge clk);
      rd_half = 1'b0;
      rd_byte = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mbr1_valid", {31'd0, mbr1_valid}, 32'd0);
      chk("R1 mbr2_valid", {31'd0, mbr2_valid}, 32'd0);
      chk("R1 mem_req", {31'd0, mem_req}, 32'd1);
      chk("R1 mem_addr", {2'b00, mem_addr}, 32'd0);

      // aligned stream, single and pair reads, R7 byte order through the scoreboard
      gnt_en = 1'b1;
      redirect(32'h40);
      for (int i = 0; i < 3; i++) read1("R4 R7");
      for (int i = 0; i < 3; i++) read2("R5", 1'b0);
      read2("R5 both strobes", 1'b1);
      for (int i = 0; i < 2; i++) read1("R4");

      // request throttling on queue room
      redirect(32'h100);
      repeat (20) @(negedge clk);
      chk("R6 no room no request", {31'd0, mem_req}, 32'd0);
      chk("R12 pair valid", {31'd0, mbr2_valid}, 32'd1);
      read2("R5", 1'b0);
      chk("R6 room then request", {31'd0, mem_req}, 32'd1);
      chk("R7 word address", {2'b00, mem_addr}, 32'h41);
      for (int i = 0; i < 4; i++) read1("R4");

      // loads while reads are in flight
      redirect(32'h200);
      redirect(32'h300);
      for (int i = 0; i < 4; i++) read1("R9 discard");
      read2("R9 discard", 1'b0);

      // unaligned load with a single byte held
      repeat (10) @(negedge clk);
      redirect(32'h403);
      wait_flag(1'b0);
      gnt_en = 1'b0;
      chk("R10 first byte", mbr1_zext, {24'd0, mem_byte(32'h403)});
      chk("R12 one byte no pair", {31'd0, mbr2_valid}, 32'd0);
      held = mbr1_zext;
      rd_half = 1'b1;
      @(negedge clk);
      rd_half = 1'b0;
      @(negedge clk);
      chk("R11 short read valid", {31'd0, mbr1_valid}, 32'd1);
      chk("R11 short read head", mbr1_zext, held);
      gnt_en = 1'b1;
      read1("R10");
      read2("R10", 1'b0);
      read2("R10", 1'b0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule